// File: doc/BRIEF.md
# MMU Protection-Fault Exception Entry Unit

This unit performs the hardware part of taking an exception when an address translation finds a valid, matching entry but that entry's protection setting forbids the current access. The lookup logic presents a fault request together with the faulting virtual address, the access kind, the way that matched, the current PC, a delay-slot flag with the address of the related branch, the live status register and the vector base. When the unit accepts the request, it commits every side effect at one clock edge. It captures the page number, the fault address, an exception code, the saved PC and the saved status. It records the way index, raises the privilege, block and bank bits of the status word, and emits the handler address. All of these appear together with a one-cycle `fire` pulse.

Requests use a valid/ready handshake. `req_ready` is high in every cycle after reset, so the unit never applies back-pressure. A request counts as transferred in any cycle where `req_valid` and `req_ready` are both high. The lookup side may therefore present one request per cycle and hold nothing. A request that arrives while the status block bit is already set is refused. The unit raises `blocked_err` for one cycle and changes no state.

The low bits of the page-table-entry-high register hold an address-space tag that the fault path must not touch. The surrounding register file loads them through `pteh_wr_en`.

Top module: `mmu_pf_entry`

## Requirements
- R1: A fault is taken only when `req_valid`, `hit_valid`, `hit_match` and `hit_denied` are all 1 and `sr_in` bit 28 (block) is 0. Any other request causes no `fire` pulse and leaves every captured register unchanged.
- R2: For a fault taken at clock edge N, `fire` is 1 for exactly the cycle after edge N. All captured registers, `sr_out` and `redirect_pc` take their new values at that same edge N.
- R3: On a fault, `pteh[31:10]` receives `fault_va[31:10]` and `pteh[9:0]` keeps its previous value. Outside a fault, `pteh_wr_en` loads `pteh` with `pteh_wr_data`.
- R4: On a fault, `tea` receives all 32 bits of `fault_va`.
- R5: On a fault, `exc_code` becomes 12'h0A0 when `acc_store` is 0 (load) and 12'h0C0 when `acc_store` is 1 (store).
- R6: On a fault, `spc` receives `cur_pc` when `in_dslot` is 0 and `branch_pc` when `in_dslot` is 1.
- R7: On a fault, `ssr` receives `sr_in` exactly as presented, before any bit is changed.
- R8: On a fault, `sr_out` equals `sr_in` with bit 30 (mode), bit 29 (bank) and bit 28 (block) set to 1, and with all other bits unchanged.
- R9: On a fault, `rc_way` receives `way_idx`.
- R10: On a fault, `redirect_pc` equals `vbr_in + 32'h100`.
- R11: A request with `req_valid`, `hit_valid`, `hit_match` and `hit_denied` all 1 while `sr_in` bit 28 is 1 gives a one-cycle `blocked_err` pulse on the next cycle. It gives no `fire` pulse and changes no captured register.
- R12: While `rst_n` is 0, all outputs are 0. In every cycle after reset, `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fault request valid |
| req_ready | output | 1 | Request accepted this cycle (high out of reset) |
| hit_valid | input | 1 | Compared entry is valid |
| hit_match | input | 1 | Compared entry matches the address |
| hit_denied | input | 1 | Protection field denies this access |
| acc_store | input | 1 | 1 = store, 0 = load |
| fault_va | input | 32 | Faulting virtual address |
| way_idx | input | 2 | Way of the matching entry |
| cur_pc | input | 32 | Address of the faulting instruction |
| in_dslot | input | 1 | Fault occurred in a delay slot |
| branch_pc | input | 32 | Address of the related delayed branch |
| sr_in | input | 32 | Current status register |
| vbr_in | input | 32 | Vector base register |
| pteh_wr_en | input | 1 | Register-file load of page-table-entry-high |
| pteh_wr_data | input | 32 | Data for that load |
| fire | output | 1 | One-cycle commit pulse |
| redirect_pc | output | 32 | Handler address |
| sr_out | output | 32 | New status value to write back |
| pteh | output | 32 | Page-table-entry-high register |
| tea | output | 32 | Fault address register |
| exc_code | output | 12 | Exception code register |
| spc | output | 32 | Saved PC register |
| ssr | output | 32 | Saved status register |
| rc_way | output | 2 | Replacement-counter way field |
| blocked_err | output | 1 | Refused request (block bit set) |

## Verification
The in-module assertions check the following on every cycle:
- `fire` and `blocked_err` are never high together.
- Any fire carries the pre-change status in `ssr`, the three raised status bits and the vector-base-plus-offset target.
- A refused request leaves the capture registers stable, and a request made with the block bit set never fires.
- The page number in `pteh` follows the faulting address.

Only the bench's scenarios can show the remaining behaviours:
- The choice between load and store codes.
- The delay-slot PC substitution.
- The preservation of the low `pteh` bits loaded earlier.
- The way capture.
- That partial hits such as a match without denial change nothing.

// File: rtl/mmu_pf_pkg.sv
package mmu_pf_pkg;
  localparam int SR_MODE_BIT  = 30;
  localparam int SR_BANK_BIT  = 29;
  localparam int SR_BLOCK_BIT = 28;
  localparam int CODE_W       = 12;
  localparam logic [CODE_W-1:0] CODE_LOAD_DENY  = 12'h0A0;
  localparam logic [CODE_W-1:0] CODE_STORE_DENY = 12'h0C0;

  typedef enum logic {ACC_LOAD = 1'b0, ACC_STORE = 1'b1} acc_kind_e;

  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_TAKE   = 2'd1,
    DEC_REFUSE = 2'd2
  } decision_e;
endpackage

// File: rtl/mmu_pf_qualify.sv
module mmu_pf_qualify (
  input  logic                  req_valid,
  input  logic                  req_ready,
  input  logic                  hit_valid,
  input  logic                  hit_match,
  input  logic                  hit_denied,
  input  logic                  blocked,
  output mmu_pf_pkg::decision_e decision
);
  import mmu_pf_pkg::*;

  logic candidate;

  always_comb begin
    candidate = req_valid && req_ready && hit_valid && hit_match && hit_denied;
    if (!candidate)   decision = DEC_IDLE;
    else if (blocked) decision = DEC_REFUSE;
    else              decision = DEC_TAKE;
  end
endmodule

// File: rtl/mmu_pf_compute.sv
module mmu_pf_compute #(
  parameter int ADDR_W  = 32,
  parameter int SR_W    = 32,
  parameter int WAY_W   = 2,
  parameter int VPN_LO  = 10,
  parameter logic [ADDR_W-1:0] VEC_OFS = 'h100
) (
  input  logic [ADDR_W-1:0]           fault_va,
  input  logic                        acc_store,
  input  logic [ADDR_W-1:0]           cur_pc,
  input  logic                        in_dslot,
  input  logic [ADDR_W-1:0]           branch_pc,
  input  logic [SR_W-1:0]             sr_in,
  input  logic [ADDR_W-1:0]           vbr_in,
  input  logic [ADDR_W-1:0]           pteh_cur,
  output logic [ADDR_W-1:0]           pteh_nxt,
  output logic [mmu_pf_pkg::CODE_W-1:0] code_nxt,
  output logic [ADDR_W-1:0]           spc_nxt,
  output logic [SR_W-1:0]             sr_nxt,
  output logic [ADDR_W-1:0]           target_nxt
);
  import mmu_pf_pkg::*;

  localparam int VPN_W = ADDR_W - VPN_LO;

  acc_kind_e kind;

  always_comb begin
    kind       = acc_kind_e'(acc_store);
    pteh_nxt   = {fault_va[ADDR_W-1 -: VPN_W], pteh_cur[VPN_LO-1:0]};
    code_nxt   = (kind == ACC_STORE) ? CODE_STORE_DENY : CODE_LOAD_DENY;
    spc_nxt    = in_dslot ? branch_pc : cur_pc;
    target_nxt = vbr_in + VEC_OFS;
    sr_nxt     = sr_in;
    sr_nxt[SR_MODE_BIT]  = 1'b1;
    sr_nxt[SR_BANK_BIT]  = 1'b1;
    sr_nxt[SR_BLOCK_BIT] = 1'b1;
  end
endmodule

// File: rtl/mmu_pf_regs.sv
module mmu_pf_regs #(
  parameter int ADDR_W = 32,
  parameter int SR_W   = 32,
  parameter int WAY_W  = 2,
  parameter logic [ADDR_W-1:0] VEC_OFS = 'h100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  mmu_pf_pkg::decision_e         decision,
  input  logic                          req_valid,
  input  logic [SR_W-1:0]               sr_in,
  input  logic [ADDR_W-1:0]             vbr_in,
  input  logic [ADDR_W-1:0]             fault_va,
  input  logic [WAY_W-1:0]              way_idx,
  input  logic [ADDR_W-1:0]             pteh_nxt,
  input  logic [mmu_pf_pkg::CODE_W-1:0] code_nxt,
  input  logic [ADDR_W-1:0]             spc_nxt,
  input  logic [SR_W-1:0]               sr_nxt,
  input  logic [ADDR_W-1:0]             target_nxt,
  input  logic                          pteh_wr_en,
  input  logic [ADDR_W-1:0]             pteh_wr_data,
  output logic                          ready_q,
  output logic                          fire_q,
  output logic                          err_q,
  output logic [ADDR_W-1:0]             pteh_q,
  output logic [ADDR_W-1:0]             tea_q,
  output logic [mmu_pf_pkg::CODE_W-1:0] code_q,
  output logic [ADDR_W-1:0]             spc_q,
  output logic [SR_W-1:0]               ssr_q,
  output logic [SR_W-1:0]               sr_out_q,
  output logic [ADDR_W-1:0]             target_q,
  output logic [WAY_W-1:0]              rc_q
);
  import mmu_pf_pkg::*;

  logic take;
  assign take = (decision == DEC_TAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      fire_q   <= 1'b0;
      err_q    <= 1'b0;
      pteh_q   <= '0;
      tea_q    <= '0;
      code_q   <= '0;
      spc_q    <= '0;
      ssr_q    <= '0;
      sr_out_q <= '0;
      target_q <= '0;
      rc_q     <= '0;
    end else begin
      ready_q <= 1'b1;
      fire_q  <= take;
      err_q   <= (decision == DEC_REFUSE);
      if (take) begin
        pteh_q   <= pteh_nxt;
        tea_q    <= fault_va;
        code_q   <= code_nxt;
        spc_q    <= spc_nxt;
        ssr_q    <= sr_in;
        sr_out_q <= sr_nxt;
        target_q <= target_nxt;
        rc_q     <= way_idx;
      end else if (pteh_wr_en) begin
        pteh_q <= pteh_wr_data;
      end
    end
  end

  AST_FIRE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_q && err_q)); // R11
  AST_SSR_PRESTATE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> ssr_q == $past(sr_in)); // R7
  AST_SR_BITS_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (sr_out_q[SR_MODE_BIT] && sr_out_q[SR_BANK_BIT] && sr_out_q[SR_BLOCK_BIT])); // R8
  AST_VECTOR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> target_q == $past(vbr_in) + VEC_OFS); // R10
  AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($stable(tea_q) && $stable(spc_q) && $stable(code_q) && $stable(ssr_q))); // R11
  AST_BLOCKED_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sr_in[SR_BLOCK_BIT]) |=> !fire_q); // R11
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (code_q == CODE_LOAD_DENY || code_q == CODE_STORE_DENY)); // R5
endmodule

// File: rtl/mmu_pf_entry.sv
module mmu_pf_entry #(
  parameter int ADDR_W = 32,
  parameter int SR_W   = 32,
  parameter int WAYS   = 4,
  parameter int VPN_LO = 10,
  parameter logic [ADDR_W-1:0] VEC_OFS = 'h100,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          hit_valid,
  input  logic                          hit_match,
  input  logic                          hit_denied,
  input  logic                          acc_store,
  input  logic [ADDR_W-1:0]             fault_va,
  input  logic [WAY_W-1:0]              way_idx,
  input  logic [ADDR_W-1:0]             cur_pc,
  input  logic                          in_dslot,
  input  logic [ADDR_W-1:0]             branch_pc,
  input  logic [SR_W-1:0]               sr_in,
  input  logic [ADDR_W-1:0]             vbr_in,
  input  logic                          pteh_wr_en,
  input  logic [ADDR_W-1:0]             pteh_wr_data,
  output logic                          fire,
  output logic [ADDR_W-1:0]             redirect_pc,
  output logic [SR_W-1:0]               sr_out,
  output logic [ADDR_W-1:0]             pteh,
  output logic [ADDR_W-1:0]             tea,
  output logic [mmu_pf_pkg::CODE_W-1:0] exc_code,
  output logic [ADDR_W-1:0]             spc,
  output logic [SR_W-1:0]               ssr,
  output logic [WAY_W-1:0]              rc_way,
  output logic                          blocked_err
);
  import mmu_pf_pkg::*;

  decision_e              decision;
  logic [ADDR_W-1:0]      pteh_nxt, spc_nxt, target_nxt;
  logic [CODE_W-1:0]      code_nxt;
  logic [SR_W-1:0]        sr_nxt;

  mmu_pf_qualify u_qualify (
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .hit_valid  (hit_valid),
    .hit_match  (hit_match),
    .hit_denied (hit_denied),
    .blocked    (sr_in[SR_BLOCK_BIT]),
    .decision   (decision)
  );

  mmu_pf_compute #(
    .ADDR_W(ADDR_W), .SR_W(SR_W), .WAY_W(WAY_W), .VPN_LO(VPN_LO), .VEC_OFS(VEC_OFS)
  ) u_compute (
    .fault_va   (fault_va),
    .acc_store  (acc_store),
    .cur_pc     (cur_pc),
    .in_dslot   (in_dslot),
    .branch_pc  (branch_pc),
    .sr_in      (sr_in),
    .vbr_in     (vbr_in),
    .pteh_cur   (pteh),
    .pteh_nxt   (pteh_nxt),
    .code_nxt   (code_nxt),
    .spc_nxt    (spc_nxt),
    .sr_nxt     (sr_nxt),
    .target_nxt (target_nxt)
  );

  mmu_pf_regs #(
    .ADDR_W(ADDR_W), .SR_W(SR_W), .WAY_W(WAY_W), .VEC_OFS(VEC_OFS)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .decision     (decision),
    .req_valid    (req_valid),
    .sr_in        (sr_in),
    .vbr_in       (vbr_in),
    .fault_va     (fault_va),
    .way_idx      (way_idx),
    .pteh_nxt     (pteh_nxt),
    .code_nxt     (code_nxt),
    .spc_nxt      (spc_nxt),
    .sr_nxt       (sr_nxt),
    .target_nxt   (target_nxt),
    .pteh_wr_en   (pteh_wr_en),
    .pteh_wr_data (pteh_wr_data),
    .ready_q      (req_ready),
    .fire_q       (fire),
    .err_q        (blocked_err),
    .pteh_q       (pteh),
    .tea_q        (tea),
    .code_q       (exc_code),
    .spc_q        (spc),
    .ssr_q        (ssr),
    .sr_out_q     (sr_out),
    .target_q     (redirect_pc),
    .rc_q         (rc_way)
  );

  AST_VPN_FOLLOWS_VA: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> pteh[ADDR_W-1:VPN_LO] == $past(fault_va[ADDR_W-1:VPN_LO])); // R3
  AST_TEA_FULL_VA: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> tea == $past(fault_va)); // R4
endmodule

// File: tb/mmu_pf_entry_bench.sv
`timescale 1ns/1ps
module mmu_pf_entry_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, hit_valid = 0, hit_match = 0, hit_denied = 0;
  logic        acc_store = 0, in_dslot = 0, pteh_wr_en = 0;
  logic [31:0] fault_va = 0, cur_pc = 0, branch_pc = 0, sr_in = 0, vbr_in = 0, pteh_wr_data = 0;
  logic [1:0]  way_idx = 0;
  logic        req_ready, fire, blocked_err;
  logic [31:0] redirect_pc, sr_out, pteh, tea, spc, ssr;
  logic [11:0] exc_code;
  logic [1:0]  rc_way;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] e_pteh = 0, e_tea = 0, e_spc = 0, e_ssr = 0, e_sr = 0, e_tgt = 0;
  logic [11:0] e_code = 0;
  logic [1:0]  e_rc = 0;

  always #2.5 clk = ~clk;

  mmu_pf_entry u_mmu_pf_entry (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .hit_valid(hit_valid), .hit_match(hit_match), .hit_denied(hit_denied),
    .acc_store(acc_store), .fault_va(fault_va), .way_idx(way_idx), .cur_pc(cur_pc),
    .in_dslot(in_dslot), .branch_pc(branch_pc), .sr_in(sr_in), .vbr_in(vbr_in),
    .pteh_wr_en(pteh_wr_en), .pteh_wr_data(pteh_wr_data), .fire(fire),
    .redirect_pc(redirect_pc), .sr_out(sr_out), .pteh(pteh), .tea(tea),
    .exc_code(exc_code), .spc(spc), .ssr(ssr), .rc_way(rc_way), .blocked_err(blocked_err)
  );

  function automatic logic [11:0] f_code(input logic st);
    return st ? 12'h0C0 : 12'h0A0;
  endfunction
  function automatic logic [31:0] f_sr(input logic [31:0] s);
    return s | 32'h7000_0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input logic e_fire, input logic e_err, input string tag);
    chk({tag, " R2 fire"}, {31'd0, fire}, {31'd0, e_fire});
    chk({tag, " R11 blocked_err"}, {31'd0, blocked_err}, {31'd0, e_err});
    chk({tag, " R3 pteh"}, pteh, e_pteh);
    chk({tag, " R4 tea"}, tea, e_tea);
    chk({tag, " R5 exc_code"}, {20'd0, exc_code}, {20'd0, e_code});
    chk({tag, " R6 spc"}, spc, e_spc);
    chk({tag, " R7 ssr"}, ssr, e_ssr);
    chk({tag, " R8 sr_out"}, sr_out, e_sr);
    chk({tag, " R9 rc_way"}, {30'd0, rc_way}, {30'd0, e_rc});
    chk({tag, " R10 redirect"}, redirect_pc, e_tgt);
    chk({tag, " R12 ready"}, {31'd0, req_ready}, 32'd1);
  endtask

  // Present one request at a falling edge; outputs are checked at the next falling edge.
  task automatic cycle(input logic v, input logic hv, input logic hm, input logic hd,
                       input logic st, input logic [31:0] va, input logic [1:0] w,
                       input logic [31:0] pc, input logic ds, input logic [31:0] bpc,
                       input logic [31:0] sr, input logic [31:0] vbr,
                       input logic we, input logic [31:0] wd, input string tag);
    logic take, refuse;
    req_valid = v; hit_valid = hv; hit_match = hm; hit_denied = hd; acc_store = st;
    fault_va = va; way_idx = w; cur_pc = pc; in_dslot = ds; branch_pc = bpc;
    sr_in = sr; vbr_in = vbr; pteh_wr_en = we; pteh_wr_data = wd;
    take   = v && hv && hm && hd && !sr[28];
    refuse = v && hv && hm && hd && sr[28];
    if (take) begin
      e_pteh = {va[31:10], e_pteh[9:0]};
      e_tea  = va;
      e_code = f_code(st);
      e_spc  = ds ? bpc : pc;
      e_ssr  = sr;
      e_sr   = f_sr(sr);
      e_tgt  = vbr + 32'h100;
      e_rc   = w;
    end else if (we) begin
      e_pteh = wd;
    end
    @(negedge clk);
    check_all(take, refuse, tag);
    req_valid = 0; pteh_wr_en = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    #12;
    // R12 reset state
    chk("R12 reset fire", {31'd0, fire}, 32'd0);
    chk("R12 reset ready", {31'd0, req_ready}, 32'd0);
    chk("R12 reset pteh", pteh, 32'd0);
    chk("R12 reset redirect", redirect_pc, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R3 preload low tag bits, then fault must keep them
    cycle(0,0,0,0,0, 0,0, 0,0,0, 0,0, 1, 32'hFFFF_F2AB, "R3 preload");
    cycle(1,1,1,1,0, 32'h1234_5678,2'd3, 32'h8000_0010,0,32'h8000_0000, 32'h0000_00F0,32'h8C00_0000, 0,0, "R5 load R6 noslot");
    chk("R3 low bits kept", {22'd0, pteh[9:0]}, 32'h2AB);
    cycle(1,1,1,1,1, 32'hABCD_EF01,2'd1, 32'h8000_0020,1,32'h8000_001C, 32'h0000_0003,32'h0000_1000, 0,0, "R5 store R6 dslot");
    cycle(0,1,1,1,1, 32'h0,2'd2, 32'h1,0,32'h2, 32'h0,32'h0, 0,0, "R1 no valid");
    cycle(1,0,1,1,1, 32'h5,2'd2, 32'h1,0,32'h2, 32'h0,32'h0, 0,0, "R1 entry invalid");
    cycle(1,1,0,1,1, 32'h5,2'd2, 32'h1,0,32'h2, 32'h0,32'h0, 0,0, "R1 no match");
    cycle(1,1,1,0,1, 32'h5,2'd2, 32'h1,0,32'h2, 32'h0,32'h0, 0,0, "R1 allowed");
    cycle(1,1,1,1,0, 32'hDEAD_0000,2'd0, 32'h44,0,32'h40, 32'h1000_0000,32'h0, 0,0, "R11 blocked");
    cycle(1,1,1,1,0, 32'hFFFF_FFFF,2'd2, 32'hFFFF_FFFE,0,32'h0, 32'h0,32'hFFFF_FF00, 0,0, "R10 wrap");
    cycle(0,0,0,0,0, 0,0, 0,0,0, 0,0, 0,0, "R2 single pulse");
    for (int i = 0; i < 300; i++) begin
      logic [3:0] hb;
      logic [31:0] srr;
      logic we;
      hb  = $urandom;
      srr = $urandom;
      if (($urandom % 3) != 0) srr[28] = 1'b0;
      if (($urandom % 2) == 0) hb = 4'hF;
      we  = (hb != 4'hF) && ($urandom % 4 == 0);
      cycle(hb[0], hb[1], hb[2], hb[3], 1'($urandom), $urandom, 2'($urandom),
            $urandom, 1'($urandom), $urandom, srr, $urandom, we, $urandom, "R1 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule